// File: doc/BRIEF.md
# SATA Port Task-File Shadow Register Block

This block keeps the host-visible shadow state of one port of a SATA host controller that follows the native command queuing model. It holds the task-file register (device status and error bytes), the device signature, a mirror of the link status, the SActive register, a running bitmap of finished queued tags, and a small interrupt status and enable pair. Software reaches these registers over a simple 32-bit register bus, addressed by byte offset.

The receive side of the port reports device-to-host events on a one-cycle event strobe. Each event names its kind (register FIS, PIO setup FIS or set-device-bits FIS) and carries the device error and status bytes. A set-device-bits event also carries a bitmap of the tags that have finished. A register or PIO setup event replaces the whole status byte. A set-device-bits event keeps the busy and data-request bits that the shadow already holds. The set-device-bits event also builds an 8-byte receive image for the port's receive area. An event marked as cancelled is dropped completely. A port reset puts every register back to its defined power-up value.

Top module: `port_shadow_regs`

## Requirements
- R1: A read of offset 0x00 returns the task-file register, with the error byte in bits 15:8, the status byte in bits 7:0 and zero in bits 31:16.
- R2: Host writes to offsets 0x00 (task file), 0x04 (signature) and 0x08 (link status) change no register. The link status register at 0x08 follows the `linkStatus` input with one register stage.
- R3: While `portReset` is high, or while `rstN` is low, the block takes these values: task file 0x0000007F, signature 0xFFFFFFFF, and zero for link status, SActive, finished bitmap, interrupt status, interrupt enable and receive image. Port reset wins over any event or write in the same cycle.
- R4: A set-device-bits event (`evKind` = 3) loads the task file with (error << 8) | (status & 0x77) | (old & 0x88), so busy (bit 7) and data-request (bit 3) keep their old values.
- R5: A register FIS event (`evKind` = 1) or a PIO setup event (`evKind` = 2) loads the task file with (error << 8) | status, using the whole status byte. `evKind` = 0 is no event.
- R6: A register FIS or PIO setup event whose status bit 0 (ERR) is set raises interrupt status bit 0 (task-file error).
- R7: A set-device-bits event loads `sdbImage` as follows. Bits 7:0 hold the error byte. Bits 23:16 hold status & 0x77. Bits 15:8 and 31:24 are zero. Bits 63:32 hold the updated finished bitmap, so byte 4 of the image is the bitmap's low byte. The same event raises interrupt status bit 1.
- R8: The finished bitmap (read at 0x1C) is the OR of all `evFinished` values from set-device-bits events since reset. The same event clears those tags in SActive. A host write to 0x10 sets the SActive bits that are written as one.
- R9: An event with `evCancel` high changes no register, no receive image bit and no interrupt status bit.
- R10: The interrupt status register at 0x14 is write-one-to-clear, and a new event in the same cycle wins over the clear. The interrupt enable register at 0x18 is read/write (bits 1:0). `irq` is high when any status bit is set together with its enable bit.
- R11: Read data appears on `busRdData` one cycle after a cycle with `busRdEn` high. Offsets 0x20 and above read as zero, and `busRdData` is zero in every cycle that does not follow a read strobe.
- R12: The signature register (offset 0x04) is loaded from `sigIn` in a cycle where `sigLoad` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| portReset | input | 1 | Port reset, same effect as rstN |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 6 | Byte offset, word aligned |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after busRdEn |
| evValid | input | 1 | Device-to-host event strobe |
| evKind | input | 2 | 1 register FIS, 2 PIO setup, 3 set-device-bits |
| evError | input | 8 | Device error byte |
| evStatus | input | 8 | Device status byte |
| evFinished | input | 32 | Finished tag bitmap (set-device-bits) |
| evCancel | input | 1 | Event was cancelled and must be dropped |
| sigLoad | input | 1 | Load strobe for the signature |
| sigIn | input | 32 | Device signature value |
| linkStatus | input | 32 | Current link status word |
| sdbImage | output | 64 | Set-device-bits receive image, byte 0 in bits 7:0 |
| irq | output | 1 | Port interrupt |

## Verification
An event, a signature load or a host write takes effect at the clock edge that samples it. A read issued in the next cycle therefore returns the new value one edge after its own strobe. `sdbImage` and `irq` change at that first edge. The bench drives every strobe for a single cycle starting at a falling edge. It samples `sdbImage` and `irq` at the following falling edge, and it samples read data at the falling edge after the read strobe's rising edge, when `busRdEn` has not yet been deasserted by the design's view. The next falling edge then shows zero on `busRdData`.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_REG  = 2'd1,
    EV_PIO  = 2'd2,
    EV_SDB  = 2'd3
  } evKind_e;

  typedef enum logic [2:0] {
    SEL_TFD,
    SEL_SIG,
    SEL_LINK,
    SEL_SACT,
    SEL_IST,
    SEL_IEN,
    SEL_DONE,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   loadFull;
    logic   loadSdb;
    logic   raiseTfErr;
    logic   raiseSdb;
    logic   loadSig;
    logic   wrIen;
    logic   clrIst;
    logic   setSact;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;

  localparam int unsigned IRQ_BITS = 2;

endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              evValid,
  input  logic [1:0]        evKind,
  input  logic [7:0]        evStatus,
  input  logic              evCancel,
  input  logic              sigLoad,
  output strobes_t          strb
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              evLive;
  logic              isFull;
  logic              isSdb;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign evLive  = evValid && !evCancel;
  assign isFull  = evLive && (evKind == EV_REG || evKind == EV_PIO);
  assign isSdb   = evLive && (evKind == EV_SDB);

  always_comb begin
    strb            = '0;
    strb.loadFull   = isFull;
    strb.loadSdb    = isSdb;
    strb.raiseTfErr = isFull && evStatus[0];
    strb.raiseSdb   = isSdb;
    strb.loadSig    = sigLoad;
    strb.rdEn       = busRdEn;
    strb.rdSel      = SEL_NONE;
    case (wordIdx)
      WORD_W'(0): strb.rdSel = SEL_TFD;
      WORD_W'(1): strb.rdSel = SEL_SIG;
      WORD_W'(2): strb.rdSel = SEL_LINK;
      WORD_W'(4): begin
        strb.rdSel   = SEL_SACT;
        strb.setSact = busWrEn;
      end
      WORD_W'(5): begin
        strb.rdSel  = SEL_IST;
        strb.clrIst = busWrEn;
      end
      WORD_W'(6): begin
        strb.rdSel = SEL_IEN;
        strb.wrIen = busWrEn;
      end
      WORD_W'(7): strb.rdSel = SEL_DONE;
      default:    strb.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/shadow_data.sv
module shadow_data
  import shadow_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portReset,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [7:0]        evError,
  input  logic [7:0]        evStatus,
  input  logic [TAG_W-1:0]  evFinished,
  input  logic [DATA_W-1:0] sigIn,
  input  logic [DATA_W-1:0] linkStatus,
  output logic [DATA_W-1:0] busRdData,
  output logic [TAG_W+31:0] sdbImage,
  output logic [DATA_W-1:0] tfdVal,
  output logic [IRQ_BITS-1:0] istVal,
  output logic [IRQ_BITS-1:0] ienVal
);

  localparam logic [7:0] KEEP_MASK = 8'h88;
  localparam logic [7:0] TAKE_MASK = 8'h77;

  logic [15:0]         tfdQ;
  logic [DATA_W-1:0]   sigQ;
  logic [DATA_W-1:0]   linkQ;
  logic [TAG_W-1:0]    sactQ;
  logic [TAG_W-1:0]    doneQ;
  logic [IRQ_BITS-1:0] istQ;
  logic [IRQ_BITS-1:0] ienQ;
  logic [TAG_W+31:0]   imgQ;
  logic [DATA_W-1:0]   rdQ;
  logic [TAG_W-1:0]    doneNext;
  logic [TAG_W-1:0]    finMask;
  logic [TAG_W-1:0]    sactSet;
  logic [IRQ_BITS-1:0] istClr;
  logic [IRQ_BITS-1:0] istSet;
  logic [DATA_W-1:0]   rdMux;

  assign finMask  = strb.loadSdb ? evFinished : '0;
  assign doneNext = doneQ | finMask;
  assign sactSet  = strb.setSact ? busWrData[TAG_W-1:0] : '0;
  assign istClr   = strb.clrIst ? busWrData[IRQ_BITS-1:0] : '0;
  assign istSet   = {strb.raiseSdb, strb.raiseTfErr};

  always_comb begin
    case (strb.rdSel)
      SEL_TFD:  rdMux = DATA_W'(tfdQ);
      SEL_SIG:  rdMux = sigQ;
      SEL_LINK: rdMux = linkQ;
      SEL_SACT: rdMux = DATA_W'(sactQ);
      SEL_IST:  rdMux = DATA_W'(istQ);
      SEL_IEN:  rdMux = DATA_W'(ienQ);
      SEL_DONE: rdMux = DATA_W'(doneQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || portReset) begin
      tfdQ  <= 16'h007F;
      sigQ  <= '1;
      linkQ <= '0;
      sactQ <= '0;
      doneQ <= '0;
      istQ  <= '0;
      ienQ  <= '0;
      imgQ  <= '0;
      rdQ   <= '0;
    end else begin
      if (strb.loadFull) begin
        tfdQ <= {evError, evStatus};
      end else if (strb.loadSdb) begin
        tfdQ <= {evError, (evStatus & TAKE_MASK) | (tfdQ[7:0] & KEEP_MASK)};
      end
      if (strb.loadSig) sigQ <= sigIn;
      linkQ <= linkStatus;
      sactQ <= (sactQ | sactSet) & ~finMask;
      doneQ <= doneNext;
      istQ  <= (istQ & ~istClr) | istSet;
      if (strb.wrIen) ienQ <= busWrData[IRQ_BITS-1:0];
      if (strb.loadSdb) begin
        imgQ <= {doneNext, 8'h00, evStatus & TAKE_MASK, 8'h00, evError};
      end
      rdQ <= strb.rdEn ? rdMux : '0;
    end
  end

  assign busRdData = rdQ;
  assign sdbImage  = imgQ;
  assign tfdVal    = DATA_W'(tfdQ);
  assign istVal    = istQ;
  assign ienVal    = ienQ;

endmodule

// File: rtl/port_shadow_regs.sv
module port_shadow_regs
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portReset,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              evValid,
  input  logic [1:0]        evKind,
  input  logic [7:0]        evError,
  input  logic [7:0]        evStatus,
  input  logic [TAG_W-1:0]  evFinished,
  input  logic              evCancel,
  input  logic              sigLoad,
  input  logic [DATA_W-1:0] sigIn,
  input  logic [DATA_W-1:0] linkStatus,
  output logic [TAG_W+31:0] sdbImage,
  output logic              irq
);

  strobes_t            strb;
  logic [DATA_W-1:0]   tfdVal;
  logic [IRQ_BITS-1:0] istVal;
  logic [IRQ_BITS-1:0] ienVal;

  shadow_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .evValid  (evValid),
    .evKind   (evKind),
    .evStatus (evStatus),
    .evCancel (evCancel),
    .sigLoad  (sigLoad),
    .strb     (strb)
  );

  shadow_data #(.DATA_W(DATA_W), .TAG_W(TAG_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .portReset  (portReset),
    .strb       (strb),
    .busWrData  (busWrData),
    .evError    (evError),
    .evStatus   (evStatus),
    .evFinished (evFinished),
    .sigIn      (sigIn),
    .linkStatus (linkStatus),
    .busRdData  (busRdData),
    .sdbImage   (sdbImage),
    .tfdVal     (tfdVal),
    .istVal     (istVal),
    .ienVal     (ienVal)
  );

  assign irq = |(istVal & ienVal);

endmodule

// File: rtl/shadow_checker.sv
module shadow_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              portReset,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic              evValid,
  input logic [1:0]        evKind,
  input logic [7:0]        evError,
  input logic [7:0]        evStatus,
  input logic              evCancel,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] tfdVal,
  input logic [1:0]        istVal
);

  logic liveFull;
  logic liveSdb;
  logic quiet;

  assign liveFull = rstN && !portReset && evValid && !evCancel && (evKind == 2'd1 || evKind == 2'd2);
  assign liveSdb  = rstN && !portReset && evValid && !evCancel && evKind == 2'd3;
  assign quiet    = rstN && !portReset && !busWrEn && (!evValid || evCancel);

  AST_RESET_TFD: assert property (@(posedge clk) disable iff (!rstN)
    portReset |=> tfdVal == 32'h7F); // R3

  AST_SDB_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    liveSdb |=> (tfdVal[7] == $past(tfdVal[7])) && (tfdVal[3] == $past(tfdVal[3]))); // R4

  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    liveFull |=> tfdVal == {16'h0, $past(evError), $past(evStatus)}); // R5

  AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (liveFull && evStatus[0]) |=> istVal[0]); // R6

  AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> $stable(tfdVal) && $stable(istVal)); // R9

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == '0); // R11

endmodule

bind port_shadow_regs shadow_checker #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .portReset (portReset),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .evValid   (evValid),
  .evKind    (evKind),
  .evError   (evError),
  .evStatus  (evStatus),
  .evCancel  (evCancel),
  .busRdData (busRdData),
  .tfdVal    (tfdVal),
  .istVal    (istVal)
);

// File: tb/sim_port_shadow_regs.sv
module sim_port_shadow_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portReset = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        evValid = 1'b0;
  logic [1:0]  evKind = '0;
  logic [7:0]  evError = '0;
  logic [7:0]  evStatus = '0;
  logic [31:0] evFinished = '0;
  logic        evCancel = 1'b0;
  logic        sigLoad = 1'b0;
  logic [31:0] sigIn = '0;
  logic [31:0] linkStatus = '0;
  logic [63:0] sdbImage;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  port_shadow_regs u0 (
    .clk(clk), .rstN(rstN), .portReset(portReset),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .evValid(evValid), .evKind(evKind), .evError(evError),
    .evStatus(evStatus), .evFinished(evFinished), .evCancel(evCancel),
    .sigLoad(sigLoad), .sigIn(sigIn), .linkStatus(linkStatus),
    .sdbImage(sdbImage), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdData;
  endtask

  task automatic sendEvent(input logic [1:0] kind, input logic [7:0] err, input logic [7:0] st,
                           input logic [31:0] fin, input logic cancel);
    @(negedge clk);
    evValid = 1'b1; evKind = kind; evError = err; evStatus = st;
    evFinished = fin; evCancel = cancel;
    @(negedge clk);
    evValid = 1'b0; evCancel = 1'b0;
  endtask

  task automatic doPortReset();
    @(negedge clk);
    portReset = 1'b1;
    @(negedge clk);
    portReset = 1'b0;
  endtask

  task automatic testResetValues();
    logic [31:0] v;
    busRead(6'h00, v); check("R3 tfd", v, 32'h7F);
    check("R1 upper bits zero", v[31:16], 0);
    busRead(6'h04, v); check("R3 sig", v, 32'hFFFF_FFFF);
    busRead(6'h10, v); check("R3 sact", v, 0);
    busRead(6'h1C, v); check("R3 done bitmap", v, 0);
    busRead(6'h14, v); check("R3 ist", v, 0);
    check("R3 image", sdbImage, 0);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    busWrite(6'h00, 32'h1234);
    busWrite(6'h04, 32'hAAAA_5555);
    busWrite(6'h08, 32'h0000_0123);
    busRead(6'h00, v); check("R2 tfd write ignored", v, 32'h7F);
    busRead(6'h04, v); check("R2 sig write ignored", v, 32'hFFFF_FFFF);
    busRead(6'h08, v); check("R2 link mirrors input", v, 32'h0000_0113);
  endtask

  task automatic testSignature();
    logic [31:0] v;
    @(negedge clk); sigLoad = 1'b1; sigIn = 32'hEB14_0101;
    @(negedge clk); sigLoad = 1'b0;
    busRead(6'h04, v); check("R12 sig load", v, 32'hEB14_0101);
  endtask

  task automatic testFullLoad();
    logic [31:0] v;
    busWrite(6'h18, 32'h3);
    sendEvent(2'd1, 8'h04, 8'h51, 0, 1'b0);
    check("R6 irq after err", irq, 1);
    busRead(6'h00, v); check("R5 reg fis load", v, 32'h0451);
    busRead(6'h14, v); check("R6 ist bit0", v, 32'h1);
    busWrite(6'h14, 32'h1);
    check("R10 irq after w1c", irq, 0);
    sendEvent(2'd2, 8'h00, 8'h88, 0, 1'b0);
    busRead(6'h00, v); check("R5 pio full status", v, 32'h0088);
    busRead(6'h14, v); check("R6 no err no raise", v, 0);
  endtask

  task automatic testSdb();
    logic [31:0] v;
    busWrite(6'h10, 32'h0000_00F0);
    busRead(6'h10, v); check("R8 sact set", v, 32'hF0);
    sendEvent(2'd3, 8'h05, 8'hC1, 32'h0000_0030, 1'b0);
    check("R7 image", sdbImage, {32'h30, 8'h00, 8'h41, 8'h00, 8'h05});
    busRead(6'h00, v); check("R4 sdb keeps bsy drq", v, 32'h05C9);
    busRead(6'h14, v); check("R7 ist bit1", v, 32'h2);
    check("R10 irq sdb", irq, 1);
    busRead(6'h10, v); check("R8 sact cleared", v, 32'hC0);
    sendEvent(2'd1, 8'h00, 8'h40, 0, 1'b0);
    sendEvent(2'd3, 8'h00, 8'hFF, 32'h0000_0080, 1'b0);
    busRead(6'h00, v); check("R4 sdb keeps clear bits", v, 32'h0077);
    busRead(6'h1C, v); check("R8 bitmap accumulates", v, 32'hB0);
    check("R7 image bitmap", sdbImage[63:32], 32'hB0);
  endtask

  task automatic testCancel();
    logic [31:0] v;
    busWrite(6'h14, 32'h3);
    sendEvent(2'd3, 8'h11, 8'h22, 32'h0000_0040, 1'b1);
    sendEvent(2'd1, 8'h11, 8'h23, 0, 1'b1);
    busRead(6'h00, v); check("R9 tfd unchanged", v, 32'h0077);
    busRead(6'h14, v); check("R9 ist unchanged", v, 0);
    busRead(6'h10, v); check("R9 sact unchanged", v, 32'h40);
    busRead(6'h1C, v); check("R9 bitmap unchanged", v, 32'hB0);
    check("R9 image unchanged", sdbImage[7:0], 8'h00);
  endtask

  task automatic testReadTiming();
    logic [31:0] v;
    busRead(6'h18, v); check("R10 ien readback", v, 32'h3);
    busRead(6'h20, v); check("R11 unmapped zero", v, 0);
    busRead(6'h3C, v); check("R11 unmapped high", v, 0);
    @(negedge clk); busRdEn = 1'b1; busAddr = 6'h00;
    @(negedge clk); busRdEn = 1'b0;
    check("R11 data one cycle later", busRdData, 32'h0077);
    @(negedge clk);
    check("R11 idle zero", busRdData, 0);
  endtask

  task automatic testPortReset();
    logic [31:0] v;
    @(negedge clk);
    portReset = 1'b1; evValid = 1'b1; evKind = 2'd1; evStatus = 8'h01;
    @(negedge clk);
    portReset = 1'b0; evValid = 1'b0;
    check("R3 irq after reset", irq, 0);
    check("R3 image cleared", sdbImage, 0);
    busRead(6'h00, v); check("R3 tfd after port reset", v, 32'h7F);
    busRead(6'h04, v); check("R3 sig after port reset", v, 32'hFFFF_FFFF);
    busRead(6'h10, v); check("R3 sact after port reset", v, 0);
    busRead(6'h18, v); check("R3 ien after port reset", v, 0);
  endtask

  initial begin
    linkStatus = 32'h0000_0113;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testResetValues();
    testReadOnly();
    testSignature();
    testFullLoad();
    testSdb();
    testCancel();
    testReadTiming();
    testPortReset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule